// File: doc/BRIEF.md
# Dual-Issue Instruction Pair Sequencer

This block sits between fetch and two execution units: a memory unit and an integer unit. It reads the two format bits of each 64-bit instruction word and decides how the word's operations go out. A long word issues once. A parallel pair sends both halves out together, one to each unit. An ordered pair sends one half, commits it, and then sends the other half in the next cycle. Execution returns a branch flag, a branch target and a kill flag for each issue slot in the same cycle. The sequencer then raises the commit and done strobes and produces a single next-address result.

The upper half of the word (bits 63:32) is the left operation and the lower half (bits 31:0) is the right operation. An ordered pair holds `ready` low during its second cycle. In that cycle the fetch side must wait.

Top module: `pair_seq`

## Requirements
- R1: The format is {word[63], word[31]}. The encodings are: 3 long, 0 parallel, 1 left-then-right, 2 right-then-left. The issue unit codes are: 0 any unit, 1 memory unit, 2 integer unit, 3 long (whole word).
- R2: A long word is accepted and finished in one cycle. In that cycle slot A is valid with unit 3, `issueOpA` = word[63:32], `issueOpB` = word[31:0] and slot B is not valid. `commit` and `done` are both high. `nextValid`/`nextAddr` follow slot A's branch response.
- R3: In the first cycle of a left-then-right pair, slot A issues word[63:32] on the memory unit (code 1) and `commit` is high.
- R4: In the first cycle of a right-then-left pair, slot A issues word[31:0] on the integer unit (code 2) and `commit` is high.
- R5: If an ordered pair's first operation neither branches nor kills, `done` stays low and `ready` drops for exactly one cycle. In that cycle slot A issues the other half with unit code 0, `commit` and `done` are high, and the next address follows slot A's branch response. `ready` is high again afterwards.
- R6: If an ordered pair's first operation branches or asserts kill, the second operation is dropped. `done` is high in the first cycle, the next address follows that cycle's response, and `ready` stays high.
- R7: A parallel pair finishes in one cycle. Slot A issues word[63:32] on unit 1 and slot B issues word[31:0] on unit 2. There is a single commit pulse and `done` is high.
- R8: For a parallel pair, the result depends on which slots branch. With no branch, `nextValid` is 0 and `nextAddr` is 0. With exactly one branch, `nextValid` is 1 and `nextAddr` is that slot's target. With two branches, `error` is 1, `nextValid` is 0 and `nextAddr` is 0.
- R9: `wordValid` and `word` are ignored while `ready` is low. A word offered in that cycle is neither issued then nor later.
- R10: After reset, `ready` is high. With `wordValid` low, no slot issues and neither `commit` nor `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Instruction word offered |
| word | input | 64 | Instruction word |
| ready | output | 1 | Word can be accepted this cycle |
| issueValidA | output | 1 | Slot A carries an operation |
| issueUnitA | output | 2 | Slot A unit code |
| issueOpA | output | 32 | Slot A operation |
| issueValidB | output | 1 | Slot B carries an operation (parallel only) |
| issueUnitB | output | 2 | Slot B unit code |
| issueOpB | output | 32 | Slot B operation (lower half of word) |
| branchA | input | 1 | Slot A operation branches |
| targetA | input | 32 | Slot A branch target |
| killA | input | 1 | Slot A cancels the rest of the pair |
| branchB | input | 1 | Slot B operation branches |
| targetB | input | 32 | Slot B branch target |
| commit | output | 1 | Writes of the issued operation(s) commit |
| done | output | 1 | Word finished this cycle |
| nextValid | output | 1 | A next address was produced |
| nextAddr | output | 32 | Next address, zero when none |
| error | output | 1 | Both parallel operations branched |

## Verification
The bench covers five corner cases, and each one catches a specific design mistake:
- **Format bits.** A design that decodes the format from the wrong bits, or with the bits swapped, sends ordered pairs to the wrong unit or in the wrong order.
- **Two-branch parallel pair.** Here the target must be suppressed and `error` raised. A design with a priority mux would instead quietly pick one of the targets.
- **Kill versus branch.** A kill or branch on the first operation of an ordered pair must finish the pair at once. A design that ignored either one would issue a second operation and drop `ready`.
- **Word offered while not ready.** A word presented during the second cycle must not be taken. A design that accepted it would issue a stray operation or commit once too often.
- **Kill on the second operation.** This must finish the pair cleanly, with no leftover state.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;

  typedef enum logic [1:0] {
    UNIT_ANY  = 2'd0,
    UNIT_MEM  = 2'd1,
    UNIT_INT  = 2'd2,
    UNIT_LONG = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    FMT_PAR  = 2'd0,
    FMT_LR   = 2'd1,
    FMT_RL   = 2'd2,
    FMT_LONG = 2'd3
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  issueA;
    logic  issueB;
    logic  selRight;   // slot A takes the lower half
    logic  selHeld;    // slot A takes the held half
    logic  loadHold;   // capture the half not issued now
    logic  holdRight;  // which half to capture
    logic  mergePar;   // parallel next-address merge
    logic  finish;     // word completes this cycle
    unit_e unitA;
  } seq_ctl_t;

endpackage

// File: rtl/pair_seq_ctrl.sv
module pair_seq_ctrl
  import pair_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wordValid,
  input  fmt_e     fmt,
  input  logic     branchA,
  input  logic     killA,
  output seq_ctl_t ctl,
  output logic     ready,
  output logic     commit,
  output logic     done
);

  logic pending;
  logic nextPending;

  always_comb begin
    ctl         = '0;
    ctl.unitA   = UNIT_ANY;
    commit      = 1'b0;
    nextPending = pending;
    ready       = !pending;
    if (pending) begin
      // second operation of an ordered pair
      ctl.issueA  = 1'b1;
      ctl.selHeld = 1'b1;
      ctl.unitA   = UNIT_ANY;
      ctl.finish  = 1'b1;
      commit      = 1'b1;
      nextPending = 1'b0;
    end else if (wordValid) begin
      ctl.issueA = 1'b1;
      commit     = 1'b1;
      unique case (fmt)
        FMT_LONG: begin
          ctl.unitA  = UNIT_LONG;
          ctl.finish = 1'b1;
        end
        FMT_PAR: begin
          ctl.issueB   = 1'b1;
          ctl.unitA    = UNIT_MEM;
          ctl.mergePar = 1'b1;
          ctl.finish   = 1'b1;
        end
        FMT_LR, FMT_RL: begin
          ctl.selRight  = (fmt == FMT_RL);
          ctl.unitA     = (fmt == FMT_RL) ? UNIT_INT : UNIT_MEM;
          ctl.loadHold  = 1'b1;
          ctl.holdRight = (fmt == FMT_LR);
          if (branchA || killA) begin
            ctl.finish = 1'b1;
          end else begin
            nextPending = 1'b1;
          end
        end
        default: ;
      endcase
    end
    done = ctl.finish;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else begin
      pending <= nextPending;
    end
  end

endmodule

// File: rtl/pair_seq_dp.sv
module pair_seq_dp
  import pair_seq_pkg::*;
#(
  parameter int OP_W   = 32,
  parameter int ADDR_W = 32,
  localparam int WORD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic [WORD_W-1:0] word,
  input  logic              branchA,
  input  logic [ADDR_W-1:0] targetA,
  input  logic              branchB,
  input  logic [ADDR_W-1:0] targetB,
  output logic              issueValidA,
  output logic [1:0]        issueUnitA,
  output logic [OP_W-1:0]   issueOpA,
  output logic              issueValidB,
  output logic [1:0]        issueUnitB,
  output logic [OP_W-1:0]   issueOpB,
  output logic              nextValid,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              error
);

  logic [OP_W-1:0] leftOp;
  logic [OP_W-1:0] rightOp;
  logic [OP_W-1:0] heldOp;

  assign leftOp  = word[WORD_W-1:OP_W];
  assign rightOp = word[OP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldOp <= '0;
    end else if (ctl.loadHold) begin
      heldOp <= ctl.holdRight ? rightOp : leftOp;
    end
  end

  assign issueValidA = ctl.issueA;
  assign issueUnitA  = ctl.unitA;
  assign issueOpA    = ctl.selHeld ? heldOp : (ctl.selRight ? rightOp : leftOp);
  assign issueValidB = ctl.issueB;
  assign issueUnitB  = ctl.issueB ? UNIT_INT : UNIT_ANY;
  assign issueOpB    = rightOp;

  always_comb begin
    nextValid = 1'b0;
    nextAddr  = '0;
    error     = 1'b0;
    if (ctl.finish) begin
      if (ctl.mergePar) begin
        unique case ({branchA, branchB})
          2'b10: begin nextValid = 1'b1; nextAddr = targetA; end
          2'b01: begin nextValid = 1'b1; nextAddr = targetB; end
          2'b11: error = 1'b1;
          default: ;
        endcase
      end else if (branchA) begin
        nextValid = 1'b1;
        nextAddr  = targetA;
      end
    end
  end

endmodule

// File: rtl/pair_seq.sv
module pair_seq
  import pair_seq_pkg::*;
#(
  parameter int OP_W   = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wordValid,
  input  logic [2*OP_W-1:0]   word,
  output logic                ready,
  output logic                issueValidA,
  output logic [1:0]          issueUnitA,
  output logic [OP_W-1:0]     issueOpA,
  output logic                issueValidB,
  output logic [1:0]          issueUnitB,
  output logic [OP_W-1:0]     issueOpB,
  input  logic                branchA,
  input  logic [ADDR_W-1:0]   targetA,
  input  logic                killA,
  input  logic                branchB,
  input  logic [ADDR_W-1:0]   targetB,
  output logic                commit,
  output logic                done,
  output logic                nextValid,
  output logic [ADDR_W-1:0]   nextAddr,
  output logic                error
);

  localparam int WORD_W = 2 * OP_W;

  seq_ctl_t ctl;
  fmt_e     fmt;

  // format bits: MSB-first bit 0 and bit 32
  assign fmt = fmt_e'({word[WORD_W-1], word[OP_W-1]});

  pair_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wordValid(wordValid),
    .fmt      (fmt),
    .branchA  (branchA),
    .killA    (killA),
    .ctl      (ctl),
    .ready    (ready),
    .commit   (commit),
    .done     (done)
  );

  pair_seq_dp #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .word       (word),
    .branchA    (branchA),
    .targetA    (targetA),
    .branchB    (branchB),
    .targetB    (targetB),
    .issueValidA(issueValidA),
    .issueUnitA (issueUnitA),
    .issueOpA   (issueOpA),
    .issueValidB(issueValidB),
    .issueUnitB (issueUnitB),
    .issueOpB   (issueOpB),
    .nextValid  (nextValid),
    .nextAddr   (nextAddr),
    .error      (error)
  );

endmodule

// File: rtl/pair_seq_check.sv
module pair_seq_check #(
  parameter int OP_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordValid,
  input logic [2*OP_W-1:0] word,
  input logic              ready,
  input logic              issueValidA,
  input logic [1:0]        issueUnitA,
  input logic [OP_W-1:0]   issueOpA,
  input logic              issueValidB,
  input logic              branchA,
  input logic              killA,
  input logic              branchB,
  input logic              commit,
  input logic              done,
  input logic              nextValid,
  input logic              error
);

  logic lrStart;
  logic orderedStart;
  assign lrStart      = ready && wordValid && !word[2*OP_W-1] && word[OP_W-1];
  assign orderedStart = ready && wordValid && (word[2*OP_W-1] != word[OP_W-1]);

  p_commit_issue_r2: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> issueValidA);

  p_second_op_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lrStart && !branchA && !killA) |=>
      (!ready && issueValidA && issueUnitA == 2'd0 && done &&
       issueOpA == $past(word[OP_W-1:0])));

  p_ready_back_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ready);

  p_drop_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (orderedStart && (branchA || killA)) |-> done);

  p_drop_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (orderedStart && (branchA || killA)) |=> ready);

  p_error_both_r8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (issueValidB && branchA && branchB && !nextValid));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !wordValid) |-> (!issueValidA && !commit && !done));

endmodule

bind pair_seq pair_seq_check #(.OP_W(OP_W)) u_check (.*);

// File: tb/pair_seq_test.sv
module pair_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [63:0] word = '0;
  logic        ready;
  logic        issueValidA;
  logic [1:0]  issueUnitA;
  logic [31:0] issueOpA;
  logic        issueValidB;
  logic [1:0]  issueUnitB;
  logic [31:0] issueOpB;
  logic        branchA = 1'b0;
  logic [31:0] targetA = '0;
  logic        killA = 1'b0;
  logic        branchB = 1'b0;
  logic [31:0] targetB = '0;
  logic        commit;
  logic        done;
  logic        nextValid;
  logic [31:0] nextAddr;
  logic        error;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pair_seq uut (.*);

  typedef struct packed {
    logic [63:0] w;
    logic        bA;
    logic [31:0] tA;
    logic        kA;
    logic        bB;
    logic [31:0] tB;
    logic [1:0]  uA;
    logic [31:0] oA;
    logic        vB;
    logic        dn;
    logic        nV;
    logic [31:0] nA;
    logic        er;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h8123_4567_8765_4321, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    2'd3, 32'h8123_4567, 1'b0, 1'b1, 1'b0, 32'h0,    1'b0},
    '{64'hA000_0001_F000_0002, 1'b1, 32'h1000, 1'b0, 1'b0, 32'h0,    2'd3, 32'hA000_0001, 1'b0, 1'b1, 1'b1, 32'h1000, 1'b0},
    '{64'h1111_1111_2222_2222, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    2'd1, 32'h1111_1111, 1'b1, 1'b1, 1'b0, 32'h0,    1'b0},
    '{64'h1111_1111_2222_2222, 1'b1, 32'h4444, 1'b0, 1'b0, 32'h0,    2'd1, 32'h1111_1111, 1'b1, 1'b1, 1'b1, 32'h4444, 1'b0},
    '{64'h1111_1111_2222_2222, 1'b0, 32'h0,    1'b0, 1'b1, 32'h5555, 2'd1, 32'h1111_1111, 1'b1, 1'b1, 1'b1, 32'h5555, 1'b0},
    '{64'h1111_1111_2222_2222, 1'b1, 32'h4444, 1'b0, 1'b1, 32'h5555, 2'd1, 32'h1111_1111, 1'b1, 1'b1, 1'b0, 32'h0,    1'b1},
    '{64'h0ABC_0000_8DEF_0001, 1'b1, 32'h6000, 1'b0, 1'b0, 32'h0,    2'd1, 32'h0ABC_0000, 1'b0, 1'b1, 1'b1, 32'h6000, 1'b0},
    '{64'h9000_0007_1234_0008, 1'b0, 32'h0,    1'b1, 1'b0, 32'h0,    2'd2, 32'h1234_0008, 1'b0, 1'b1, 1'b0, 32'h0,    1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, return just before the next rising edge
  task automatic drive(input logic v, input logic [63:0] w, input logic bA,
                       input logic [31:0] tA, input logic kA, input logic bB,
                       input logic [31:0] tB);
    @(negedge clk);
    wordValid = v; word = w; branchA = bA; targetA = tA; killA = kA;
    branchB = bB; targetB = tB;
    #(CLK_PERIOD / 2 - 1);
  endtask

  function automatic string vecTag(input int i);
    if (i < 2) return "R2";
    if (i < 6) return "R7 R8";
    return "R6";
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: idle after reset
    drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
    chk("R10 ready", ready, 1);
    chk("R10 issueValidA", issueValidA, 0);
    chk("R10 commit", commit, 0);
    chk("R10 done", done, 0);

    // R1 R2 R6 R7 R8: single-cycle words from the table
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, VECS[i].w, VECS[i].bA, VECS[i].tA, VECS[i].kA, VECS[i].bB, VECS[i].tB);
      chk({vecTag(i), " R1 unitA"}, issueUnitA, VECS[i].uA);
      chk({vecTag(i), " opA"}, issueOpA, VECS[i].oA);
      chk({vecTag(i), " validB"}, issueValidB, VECS[i].vB);
      if (VECS[i].vB) chk("R7 unitB", issueUnitB, 2);
      if (i < 2) chk("R2 opB", issueOpB, VECS[i].w[31:0]);
      chk({vecTag(i), " commit"}, commit, 1);
      chk({vecTag(i), " done"}, done, VECS[i].dn);
      chk({vecTag(i), " nextValid"}, nextValid, VECS[i].nV);
      chk({vecTag(i), " nextAddr"}, nextAddr, VECS[i].nA);
      chk({vecTag(i), " error"}, error, VECS[i].er);
      drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
      chk({vecTag(i), " ready after"}, ready, 1);
    end

    // R3 R5 R9: left-then-right, second op branches, stray word offered
    drive(1'b1, 64'h0000_00AA_8000_00BB, 1'b0, '0, 1'b0, 1'b0, '0);
    chk("R3 unitA", issueUnitA, 1);
    chk("R3 opA", issueOpA, 32'h0000_00AA);
    chk("R3 commit", commit, 1);
    chk("R5 first done", done, 0);
    drive(1'b1, 64'h8111_1111_8222_2222, 1'b1, 32'h7777, 1'b0, 1'b0, '0);
    chk("R5 ready low", ready, 0);
    chk("R9 opA held", issueOpA, 32'h8000_00BB);
    chk("R5 unitA any", issueUnitA, 0);
    chk("R5 commit", commit, 1);
    chk("R5 done", done, 1);
    chk("R5 nextValid", nextValid, 1);
    chk("R5 nextAddr", nextAddr, 32'h7777);
    drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
    chk("R5 ready back", ready, 1);
    chk("R9 no stray issue", issueValidA, 0);
    chk("R9 no stray commit", commit, 0);

    // R4 R5: right-then-left, kill on second op
    drive(1'b1, 64'hC000_0011_0000_0022, 1'b0, '0, 1'b0, 1'b0, '0);
    chk("R4 unitA", issueUnitA, 2);
    chk("R4 opA", issueOpA, 32'h0000_0022);
    chk("R4 commit", commit, 1);
    chk("R4 done", done, 0);
    drive(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, '0);
    chk("R5 opA left", issueOpA, 32'hC000_0011);
    chk("R5 unitA any", issueUnitA, 0);
    chk("R5 done kill", done, 1);
    chk("R5 nextValid kill", nextValid, 0);
    drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
    chk("R5 ready after kill", ready, 1);
    chk("R10 idle", issueValidA, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule